// File: doc/BRIEF.md
# Serial Baud Tick Generator

This block divides the module clock down to the two timing strobes a serial port needs. A 13-bit divisor sets a prescaler. The prescaler emits an oversampling tick (`tick16`) once every divisor clocks, and that tick runs at sixteen times the line rate. A 4-bit stage then passes on every sixteenth oversampling tick as a bit-rate tick (`tick_bit`). Software sets the divisor through two byte-wide registers. The upper register holds the five high divisor bits and three test control bits. The lower register holds the eight low divisor bits.

A write to the upper register is staged, and the divisor does not change until the lower register is written. A controller holds the generator in one of three named states. `GEN_IDLE` is the state after reset, before a transmit or receive enable has ever been seen. `GEN_HALT` means the generator is armed but the divisor is zero. `GEN_RUN` means it is armed with a nonzero divisor. The transitions are `GEN_IDLE`→`GEN_RUN` or `GEN_IDLE`→`GEN_HALT` on the first `tx_en`/`rx_en`, and `GEN_RUN`↔`GEN_HALT` as the divisor becomes zero or nonzero. Nothing leads back to `GEN_IDLE` except reset.

Top module: `baud_gen`

## Requirements
- R1: After reset, a read of the upper register (`addr`=0) returns 0x00, a read of the lower register (`addr`=1) returns 0x04, and the divisor is 4.
- R2: `rdata` always shows the last value written to the register picked by `addr`, including an upper byte that has not yet been committed.
- R3: The upper register's bits 7:5 take a write only while `special_mode` is 1, and they otherwise keep their value. Bits 4:0 take every write.
- R4: A write to the upper register alone leaves the divisor unchanged. A write of value L to the lower register sets the divisor to {upper[4:0], L}.
- R5: In `GEN_IDLE`, before `tx_en` or `rx_en` has been 1 at any clock edge since reset, `tick16` and `tick_bit` stay 0. Once armed, the generator stays armed after both enables return to 0.
- R6: While the divisor is 0, `tick16` and `tick_bit` stay 0.
- R7: In `GEN_RUN` with divisor D and no commit, `tick16` is a one-cycle pulse that repeats every D clocks.
- R8: `tick_bit` pulses only together with `tick16`, on every sixteenth `tick16` pulse.
- R9: When a nonzero divisor D is committed while running, the prescaler reloads. The first `tick16` comes on the D-th clock counted from the commit edge as clock 1. This also holds when the commit falls in a `tick16` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe, qualified by sel |
| addr | input | 1 | 0 = upper register, 1 = lower register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| special_mode | input | 1 | Unlocks writes to upper bits 7:5 |
| tx_en | input | 1 | Transmit enable (arms generator) |
| rx_en | input | 1 | Receive enable (arms generator) |
| tick16 | output | 1 | Oversampling tick, every divisor clocks |
| tick_bit | output | 1 | Bit-rate tick, every 16th tick16 |

## Verification
A divisor commit and a prescaler wrap can fall in the same clock. When they do, the reload must win and the count must restart. The bench provokes this by waiting at a falling edge until `tick16` is high and then issuing the lower-register write in that same cycle. It judges the result by counting the clocks to the next `tick16`, which must equal the new divisor. A second collision is an upper-register write made while ticks run. The bench judges it by checking that the tick spacing keeps the old divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int SBR_W  = 13;
    localparam int BYTE_W = 8;
    localparam int OSR    = 16;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_HALT = 2'd1,
        GEN_RUN  = 2'd2
    } gen_state_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
    parameter int BYTE_W = 8,
    parameter int SBR_W  = 13,
    parameter logic [BYTE_W-1:0] HI_RST = '0,
    parameter logic [BYTE_W-1:0] LO_RST = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              special_mode,
    output logic [BYTE_W-1:0] rdata,
    output logic [SBR_W-1:0]  div,
    output logic              load
);
    localparam int HI_DIV_W = SBR_W - BYTE_W;

    logic [BYTE_W-1:0] hi_q, lo_q;
    logic [SBR_W-1:0]  div_q;
    logic              wr_hi, wr_lo;

    assign wr_hi = sel && wr && !addr;
    assign wr_lo = sel && wr && addr;
    assign load  = wr_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= HI_RST;
            lo_q  <= LO_RST;
            div_q <= {HI_RST[HI_DIV_W-1:0], LO_RST};
        end else begin
            if (wr_hi) begin
                hi_q[HI_DIV_W-1:0] <= wdata[HI_DIV_W-1:0];
                if (special_mode)
                    hi_q[BYTE_W-1:HI_DIV_W] <= wdata[BYTE_W-1:HI_DIV_W];
            end
            if (wr_lo) begin
                lo_q  <= wdata;
                div_q <= {hi_q[HI_DIV_W-1:0], wdata};
            end
        end
    end

    assign rdata = addr ? lo_q : hi_q;
    assign div   = div_q;

    // R3
    test_bits_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !special_mode) |=> $stable(hi_q[BYTE_W-1:HI_DIV_W]));
    // R4
    hi_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(div));
endmodule

// File: rtl/baud_fsm.sv
module baud_fsm
    import baud_pkg::*;
#(
    parameter int SBR_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [SBR_W-1:0] div,
    output gen_state_t       state
);
    gen_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: if (tx_en || rx_en)
                          state_d = (div == '0) ? GEN_HALT : GEN_RUN;
            GEN_HALT: if (div != '0) state_d = GEN_RUN;
            GEN_RUN:  if (div == '0) state_d = GEN_HALT;
            default:  state_d = GEN_IDLE;
        endcase
    end

    assign state = state_q;

    // R5
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GEN_IDLE) |=> (state_q != GEN_IDLE));
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int SBR_W = 13,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [SBR_W-1:0] div,
    output logic             tick16,
    output logic             tick_bit
);
    localparam int SUB_W = $clog2(OSR);

    logic [SBR_W-1:0] cnt_q;
    logic [SUB_W-1:0] sub_q;

    assign tick16   = run && (cnt_q == div - 1'b1);
    assign tick_bit = tick16 && (sub_q == SUB_W'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || load || tick16) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sub_q <= '0;
        else if (!run)   sub_q <= '0;
        else if (tick16) sub_q <= sub_q + 1'b1;
    end

    // R8
    bit_within_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bit |-> tick16);
    // R9
    reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && run) |=> (cnt_q == '0));
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SBR_W  = 13,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              special_mode,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic              tick16,
    output logic              tick_bit
);
    logic [SBR_W-1:0] div;
    logic             load;
    gen_state_t       state;

    baud_regs #(.BYTE_W(BYTE_W), .SBR_W(SBR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .special_mode(special_mode), .rdata(rdata),
        .div(div), .load(load)
    );

    baud_fsm #(.SBR_W(SBR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .div(div), .state(state)
    );

    baud_prescale #(.SBR_W(SBR_W), .OSR(OSR)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(state == GEN_RUN), .load(load),
        .div(div), .tick16(tick16), .tick_bit(tick_bit)
    );

    // R5
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_IDLE) |-> !tick16);
    // R6
    zero_div_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !(tick16 || tick_bit));
endmodule

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
    logic clk = 0, rst_n = 0;
    logic sel = 0, wr = 0, addr = 0, special_mode = 0, tx_en = 0, rx_en = 0;
    logic [7:0] wdata = 0, rdata;
    logic tick16, tick_bit;
    int vectors = 0, errors = 0;
    logic [7:0] hi_m = 8'h00, lo_m = 8'h04;

    always #2.5 clk = ~clk;

    baud_gen u0 (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .special_mode(special_mode),
        .tx_en(tx_en), .rx_en(rx_en), .tick16(tick16), .tick_bit(tick_bit));

    function automatic int div_of(input logic [7:0] h, input logic [7:0] l);
        return int'({h[4:0], l});
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(); @(posedge clk); @(negedge clk); endtask

    // drives at a negedge, returns at the negedge after the write edge
    task automatic wreg(input logic a, input logic [7:0] d);
        sel = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        sel = 0; wr = 0;
        if (a) lo_m = d;
        else hi_m = special_mode ? d : {hi_m[7:5], d[4:0]};
    endtask

    function automatic int rd(input logic a);
        return 0;
    endfunction

    task automatic read_chk(input string req, input logic a, input logic [7:0] exp);
        addr = a; #0.1;
        check(req, rdata, exp);
    endtask

    task automatic wait_tick(output int n);
        n = 1;
        while (!tick16 && n < 20000) begin cyc(); n++; end
    endtask

    task automatic period_chk(input string req, input int exp);
        int n;
        wait_tick(n); cyc(); wait_tick(n);
        check(req, n, exp);
    endtask

    task automatic silent_chk(input string req, input int ncyc);
        int seen = 0;
        for (int i = 0; i < ncyc; i++) begin
            if (tick16 || tick_bit) seen++;
            cyc();
        end
        check(req, seen, 0);
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int n, d, bits, ticks, bad;
        void'($urandom(32'd1234));
        @(negedge clk); cyc(); rst_n = 1; cyc();

        // R1 reset values
        read_chk("R1", 0, 8'h00);
        read_chk("R1", 1, 8'h04);

        // R5 nothing before arming
        silent_chk("R5", 60);

        // R3 test bits locked
        wreg(0, 8'hFF);
        read_chk("R3", 0, 8'h1F);
        special_mode = 1; wreg(0, 8'hE0);
        read_chk("R3", 0, 8'hE0);
        wreg(0, 8'h00); special_mode = 0;
        read_chk("R2", 0, 8'h00);

        // arm with a one-cycle tx_en, then drop
        tx_en = 1; cyc(); tx_en = 0;
        period_chk("R5 sticky / R7", 4);
        period_chk("R7", 4);

        // R4 staged upper byte, read back before commit
        wreg(0, 8'h01);
        read_chk("R2", 0, 8'h01);
        period_chk("R4", 4);
        wreg(1, 8'h00);
        read_chk("R2", 1, 8'h00);
        period_chk("R4", 256);

        // random divisors with commit-to-tick latency
        wreg(0, 8'h00);
        for (int k = 0; k < 12; k++) begin
            logic [7:0] l;
            l = 8'($urandom_range(1, 40));
            wreg(1, l);
            wait_tick(n);
            check("R9", n, div_of(hi_m, lo_m));
            period_chk("R7", div_of(hi_m, lo_m));
        end

        // R9 commit in a tick cycle
        for (int k = 0; k < 4; k++) begin
            wait_tick(n);
            d = 3 + k * 5;
            wreg(1, 8'(d));
            wait_tick(n);
            check("R9 same-cycle", n, d);
        end

        // R8 bit tick every 16th tick16
        wreg(1, 8'd3);
        bits = 0; ticks = 0; bad = 0;
        while (!tick_bit) cyc();
        cyc();
        for (int i = 0; i < 3 * 16 * 3; i++) begin
            if (tick_bit && !tick16) bad++;
            if (tick16) ticks++;
            if (tick_bit) begin bits++; if (ticks != 16) bad++; ticks = 0; end
            cyc();
        end
        check("R8", bits, 3);
        check("R8", bad, 0);

        // R6 zero divisor, then recovery
        wreg(1, 8'h00);
        silent_chk("R6", 80);
        wreg(1, 8'd5);
        period_chk("R6 recover", 5);

        // R5 rx_en arms after a fresh reset
        rst_n = 0; cyc(); rst_n = 1; hi_m = 0; lo_m = 4; cyc();
        read_chk("R1", 1, 8'h04);
        silent_chk("R5", 30);
        rx_en = 1; cyc(); rx_en = 0;
        period_chk("R5 rx", 4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule